// File: doc/BRIEF.md
# Memory Block Hide Controller

This block lives in the register front end of a block-organized nonvolatile memory with 32 blocks. It keeps two registers: a hide mask, one bit per block, and a block-select register that names the block that data accesses go to. Once a hide bit is set, it stays set until the next reset. Start-up code can therefore use private blocks and then lock them away from the rest of the software, without any password.

Software reads and writes both registers over a simple synchronous register bus. The bus has an address, a write enable, write data and combinational read data. Writes take effect on the clock edge. A separate access-request input asks whether the block that is currently selected may be used. One cycle after the request, the block answers with a single-cycle grant pulse or a single-cycle deny pulse. If software tries to select a hidden block, the whole select register is zeroed rather than the write simply being rejected.

Top module: `mem_hide_gate`

## Requirements
- R1: After reset the hide mask reads 0, the select register reads 0, and both grant and deny are low.
- R2: Hide-mask bit 0 always reads 0 and ignores writes. Block 0 therefore can never be hidden, and requests to it are always granted.
- R3: A write to offset 0x50 sets every hide bit whose write-data bit is 1, all in the same edge. A read of offset 0x50 then returns the mask, with bit n standing for block n.
- R4: Writing 0 to a hide bit that is already set leaves it set.
- R5: The select register sits at offset 0x04. It keeps write-data bits 4:0 as the block number, and bits 31:5 read as 0.
- R6: A select write naming a block whose hide bit is set clears the select register to 0. A select write naming a visible block stores that block number.
- R7: A request (accReq high at an edge) while the selected block is hidden gives accDeny high for exactly the next cycle and no grant.
- R8: A request while the selected block is visible gives accGrant high for exactly the next cycle and no deny. A cycle with no request gives neither pulse.
- R9: Hiding the selected block leaves the select register unchanged. A request at the same edge as the hide write is judged against the old mask, and every later request is denied.
- R10: Reads from any other offset return 0, and writes to any other offset change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte offset |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| accReq | input | 1 | Access request for the selected block |
| accGrant | output | 1 | One-cycle grant pulse |
| accDeny | output | 1 | One-cycle deny pulse |

## Verification
The assertions assume that the bus carries at most one register write per cycle, to one offset, and that the inputs are stable around the rising edge. The assertions judge each request against the mask value held before that edge. The stimulus drives every input on the falling edge, and raises a request together with a hide write only in the one directed case that checks this ordering. Write data deliberately sets reserved bit 0 and the upper select bits, so the checks can show that those bits are dropped.

// File: rtl/mem_hide_pkg.sv
package mem_hide_pkg;
  localparam int unsigned DEF_ADDR_W   = 8;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_NUM_BLKS = 32;
  localparam logic [7:0]  HIDE_OFS     = 8'h50;
  localparam logic [7:0]  SEL_OFS      = 8'h04;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_HIDE = 2'd1,
    RD_SEL  = 2'd2
  } rdSrc_t;

  typedef struct packed {
    logic hideWr;
    logic selWr;
    logic accEval;
  } ctrlStrobes_t;
endpackage

// File: rtl/mem_hide_ctrl.sv
module mem_hide_ctrl
  import mem_hide_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              accReq,
  output ctrlStrobes_t      strobes,
  output rdSrc_t            rdSrc
);
  localparam logic [ADDR_W-1:0] HIDE_A = ADDR_W'(HIDE_OFS);
  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_OFS);

  logic hitHide;
  logic hitSel;

  assign hitHide = (regAddr == HIDE_A);
  assign hitSel  = (regAddr == SEL_A);

  always_comb begin
    strobes         = '0;
    strobes.hideWr  = regWrEn && hitHide;
    strobes.selWr   = regWrEn && hitSel;
    strobes.accEval = accReq;
  end

  always_comb begin
    if (hitHide)     rdSrc = RD_HIDE;
    else if (hitSel) rdSrc = RD_SEL;
    else             rdSrc = RD_NONE;
  end
endmodule

// File: rtl/mem_hide_dp.sv
module mem_hide_dp
  import mem_hide_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NUM_BLKS = DEF_NUM_BLKS
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strobes,
  input  rdSrc_t                      rdSrc,
  input  logic [DATA_W-1:0]           wrData,
  output logic [DATA_W-1:0]           rdData,
  output logic [NUM_BLKS-1:0]         hideMask,
  output logic [$clog2(NUM_BLKS)-1:0] selBlk,
  output logic                        accGrant,
  output logic                        accDeny
);
  localparam int unsigned BLK_W = $clog2(NUM_BLKS);

  logic [BLK_W-1:0] wrBlk;
  logic             wrBlkHidden;
  logic             selHidden;

  assign wrBlk       = wrData[BLK_W-1:0];
  assign wrBlkHidden = hideMask[wrBlk];
  assign selHidden   = hideMask[selBlk];

  generate
    if (DATA_W > NUM_BLKS) begin : g_spare
      logic unusedWrBits;
      assign unusedWrBits = ^wrData[DATA_W-1:NUM_BLKS];
    end
  endgenerate

  // Per-block sticky hide bits; block 0 is tied off.
  generate
    for (genvar g = 0; g < NUM_BLKS; g++) begin : g_hide
      if (g == 0) begin : g_fixed
        assign hideMask[g] = 1'b0;
      end else begin : g_sticky
        always_ff @(posedge clk) begin
          if (!rstN)                               hideMask[g] <= 1'b0;
          else if (strobes.hideWr && wrData[g])    hideMask[g] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)              selBlk <= '0;
    else if (strobes.selWr) selBlk <= wrBlkHidden ? '0 : wrBlk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accGrant <= 1'b0;
      accDeny  <= 1'b0;
    end else begin
      accGrant <= strobes.accEval && !selHidden;
      accDeny  <= strobes.accEval && selHidden;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSrc)
      RD_HIDE: rdData[NUM_BLKS-1:0] = hideMask;
      RD_SEL:  rdData[BLK_W-1:0]    = selBlk;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/mem_hide_gate.sv
module mem_hide_gate
  import mem_hide_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NUM_BLKS = DEF_NUM_BLKS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              accReq,
  output logic              accGrant,
  output logic              accDeny
);
  localparam int unsigned BLK_W = $clog2(NUM_BLKS);

  ctrlStrobes_t          strobes;
  rdSrc_t                rdSrc;
  logic [NUM_BLKS-1:0]   hideMask;
  logic [BLK_W-1:0]      selBlk;

  mem_hide_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .accReq  (accReq),
    .strobes (strobes),
    .rdSrc   (rdSrc)
  );

  mem_hide_dp #(.DATA_W(DATA_W), .NUM_BLKS(NUM_BLKS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdSrc    (rdSrc),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .hideMask (hideMask),
    .selBlk   (selBlk),
    .accGrant (accGrant),
    .accDeny  (accDeny)
  );
endmodule

// File: rtl/mem_hide_chk.sv
module mem_hide_chk
  import mem_hide_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NUM_BLKS = DEF_NUM_BLKS
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [ADDR_W-1:0]           regAddr,
  input logic                        regWrEn,
  input logic [DATA_W-1:0]           regWrData,
  input logic [DATA_W-1:0]           regRdData,
  input logic                        accReq,
  input logic                        accGrant,
  input logic                        accDeny,
  input logic [NUM_BLKS-1:0]         hideMask,
  input logic [$clog2(NUM_BLKS)-1:0] selBlk
);
  localparam int unsigned BLK_W = $clog2(NUM_BLKS);
  localparam logic [ADDR_W-1:0] HIDE_A = ADDR_W'(HIDE_OFS);
  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_OFS);

  // R2: reserved bit reads zero on the bus
  a_r2_bit0_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == HIDE_A) |-> (regRdData[0] == 1'b0));

  // R4: no set hide bit ever clears
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((hideMask & $past(hideMask)) == $past(hideMask)));

  // R5: upper select bits read zero
  a_r5_sel_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == SEL_A) |-> ((regRdData >> BLK_W) == '0));

  // R6: selecting a hidden block clears the register
  a_r6_hidden_sel_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == SEL_A && hideMask[regWrData[BLK_W-1:0]]) |=> (selBlk == '0));

  // R6: selecting a visible block stores it
  a_r6_visible_sel_loads: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == SEL_A && !hideMask[regWrData[BLK_W-1:0]])
      |=> (selBlk == $past(regWrData[BLK_W-1:0])));

  // R7: hidden target is denied
  a_r7_deny: assert property (@(posedge clk) disable iff (!rstN)
    (accReq && hideMask[selBlk]) |=> (accDeny && !accGrant));

  // R8: visible target is granted
  a_r8_grant: assert property (@(posedge clk) disable iff (!rstN)
    (accReq && !hideMask[selBlk]) |=> (accGrant && !accDeny));

  // R8: no request, no pulse
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !accReq |=> (!accGrant && !accDeny));

  // R9: select register only moves on its own write
  a_r9_sel_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == SEL_A) |=> $stable(selBlk));
endmodule

bind mem_hide_gate mem_hide_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BLKS(NUM_BLKS)
) u_chk (.*);

// File: tb/mem_hide_gate_tb.sv
`timescale 1ns/1ps
module mem_hide_gate_tb;
  localparam int NV = 24;
  // op: 0 = write, 1 = read check, 2 = request check (exp = {grant,deny})
  localparam logic [73:0] VEC [NV] = '{
    {2'd0, 8'h04, 32'h0000_0007, 32'h0},            // R5 select 7
    {2'd1, 8'h04, 32'h0,         32'h0000_0007},
    {2'd2, 8'h00, 32'h0,         32'h2},            // R8 grant
    {2'd0, 8'h50, 32'h0000_0081, 32'h0},            // R3 hide 7, bit0 too
    {2'd1, 8'h50, 32'h0,         32'h0000_0080},    // R2 R3
    {2'd2, 8'h00, 32'h0,         32'h1},            // R7 deny
    {2'd1, 8'h04, 32'h0,         32'h0000_0007},    // R9 sel kept
    {2'd0, 8'h50, 32'h0,         32'h0},            // R4 write zeros
    {2'd1, 8'h50, 32'h0,         32'h0000_0080},
    {2'd0, 8'h04, 32'h0000_0027, 32'h0},            // R6 hidden 7
    {2'd1, 8'h04, 32'h0,         32'h0},
    {2'd0, 8'h04, 32'hFFFF_FFE3, 32'h0},            // R5 upper bits dropped
    {2'd1, 8'h04, 32'h0,         32'h0000_0003},
    {2'd0, 8'h50, 32'hF000_0006, 32'h0},            // R3 multi-bit
    {2'd1, 8'h50, 32'h0,         32'hF000_0086},
    {2'd2, 8'h00, 32'h0,         32'h2},            // R8 block 3 visible
    {2'd0, 8'h04, 32'h0000_0002, 32'h0},            // R6 hidden 2
    {2'd1, 8'h04, 32'h0,         32'h0},
    {2'd2, 8'h00, 32'h0,         32'h2},            // R2 block 0 granted
    {2'd0, 8'h10, 32'hFFFF_FFFF, 32'h0},            // R10 stray write
    {2'd1, 8'h10, 32'h0,         32'h0},
    {2'd1, 8'h50, 32'h0,         32'hF000_0086},
    {2'd0, 8'h50, 32'hFFFF_FFFF, 32'h0},            // R3 all
    {2'd1, 8'h50, 32'h0,         32'hFFFF_FFFE}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        accReq = 1'b0;
  logic        accGrant;
  logic        accDeny;
  int          nChk = 0;
  int          nBad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mem_hide_gate u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .accReq(accReq),
    .accGrant(accGrant), .accDeny(accDeny)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic doRead(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic doReq(input string req, input logic [1:0] exp);
    @(negedge clk);
    accReq = 1'b1;
    @(negedge clk);
    accReq = 1'b0;
    check(req, {30'b0, accGrant, accDeny}, {30'b0, exp});
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 pulses", {30'b0, accGrant, accDeny}, 32'h0);
    doRead("R1 mask", 8'h50, 32'h0);
    doRead("R1 sel", 8'h04, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][73:72])
        2'd0: doWrite(VEC[i][71:64], VEC[i][63:32]);
        2'd1: doRead($sformatf("vec%0d", i), VEC[i][71:64], VEC[i][31:0]);
        default: doReq($sformatf("vec%0d", i), VEC[i][1:0]);
      endcase
    end

    // R9: same-edge hide of the selected block is judged on the old mask
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    doWrite(8'h04, 32'h9);
    @(negedge clk);
    regAddr = 8'h50; regWrData = 32'h0000_0200; regWrEn = 1'b1; accReq = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; accReq = 1'b0; regWrData = '0;
    check("R9 same-edge grant", {30'b0, accGrant, accDeny}, 32'h2);
    doReq("R9 later deny", 2'b01);
    doRead("R9 sel kept", 8'h04, 32'h9);
    // R8: idle cycle gives no pulse
    @(negedge clk);
    check("R8 idle", {30'b0, accGrant, accDeny}, 32'h0);
    // R1: reset clears sticky bits
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    doRead("R1 mask after reset", 8'h50, 32'h0);
    doRead("R1 sel after reset", 8'h04, 32'h0);
    finishRun();
  end
endmodule